// File: doc/BRIEF.md
# Display panel power sequencer

This block turns a display controller on and off by replaying fixed lists of register writes. Each write goes out through a simple command-writer handshake: a transaction kind, an 8-bit opcode and a 16-bit value. The writer, which is usually a 9-bit serial link, sends the transaction and answers with a done pulse and an error flag. Wait steps in the list are timed inside the block by a millisecond counter that is derived from the clock frequency parameter.

A power-on request starts with a warm-up. Three bare 0x00 commands go out, and each is followed by a wait of at least one millisecond. If any warm-up command fails, the sequence stops at once. Next comes a long configuration list. It brings the controller out of deep standby, switches on the analog supplies and sleep-out, and loads its tuning registers. Errors in this list do not stop it: they are gathered and reported when the list ends with display-on. A power-off request replays a short shutdown list. Both requests are idempotent, and requests that arrive while a list is running are dropped.

Top module: `panel_pwr_seq`

## Requirements
- R1: After a synchronous active-low reset, busy, panel_on, seq_done and wr_valid are all low.
- R2: A power-on request first issues three command-only (wr_kind 0) transactions with opcode 0x00. After each one, wr_valid stays low for at least CLK_HZ/1000 cycles.
- R3: If wr_err is high with wr_done on any of the three warm-up transactions, the block issues no further transaction, pulses seq_done with seq_err high, and panel_on stays low.
- R4: After warm-up, the transactions follow the fixed order. It opens with 0xB0=0x17, 0xBC=0x80, 0x3B=0x00, 0xB0=0x16, 0xB8=0xFFF9 (16-bit) and a lone 0x11 command, and it ends with the lone command 0x29. There are 44 transactions in all.
- R5: wr_kind 1 carries one data byte in wr_data[7:0] with wr_data[15:8] zero, and wr_kind 2 carries a 16-bit value. Register 0xB3 is written with 0x11 in two back-to-back transactions, and 0xC3 is written with 0x2040 as kind 2. wr_kind 3 never appears on the interface.
- R6: An error in a configuration transaction does not stop the list. All 44 transactions are issued, seq_done comes with seq_err high, and panel_on is set.
- R7: A power-on that completes without error pulses seq_done with seq_err low, and panel_on rises in the same cycle.
- R8: A power-off request while panel_on is high issues, in this order: command 0x28, 0xB8=0x8002 (16-bit), command 0x10, and 0xB0=0x00 (8-bit). panel_on then falls in the same cycle as seq_done.
- R9: A power-on request while panel_on is high issues no transaction. It pulses seq_done with seq_err low in the cycle after the request, and busy stays low.
- R10: A power-off request while panel_on is low has no effect: no transaction, no seq_done, and busy stays low.
- R11: Requests made while busy is high are ignored. busy stays high until the running list finishes, and that list produces exactly one seq_done.
- R12: wr_valid is held, with wr_kind, wr_op and wr_data stable, until wr_done is seen.
- R13: An error during the power-off list is accumulated and reported with seq_done, and panel_on still falls.
- R14: When both requests arrive in the same cycle while idle, the power-on request takes priority and the power-off request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| on_req | input | 1 | Power-on request pulse |
| off_req | input | 1 | Power-off request pulse |
| wr_done | input | 1 | Writer finished the current transaction |
| wr_err | input | 1 | Writer error, qualified by wr_done |
| wr_valid | output | 1 | Transaction requested |
| wr_kind | output | 2 | 0 command only, 1 one data byte, 2 two data bytes |
| wr_op | output | 8 | Register opcode |
| wr_data | output | 16 | Data value |
| busy | output | 1 | A list is running |
| panel_on | output | 1 | Panel state is active |
| seq_done | output | 1 | One-cycle completion pulse |
| seq_err | output | 1 | Completion carried an error, valid with seq_done |

## Verification
The hardest cases to reach are the ones that depend on which transaction fails. An abort can only happen on a warm-up command, while a failure later in the list must be absorbed and reported only at the end. To reach both, the bench's writer model injects wr_err at a chosen transaction index within the current sequence. One run fails the second warm-up command, another fails two configuration steps, and a third fails a shutdown step. The bench also raises both requests together partway through a running list, at a point it chooses by counting transactions. Separately, it raises both requests together while idle and panel_on is low, and checks that the power-on request is the one taken.

// File: rtl/panel_pwr_seq_pkg.sv
// Package: step encoding and the fixed step table for the panel power sequencer.
// Assumes: the power-on list occupies indices 0..ON_STEPS-1, the power-off
// list follows directly, and wait steps never end a list.
package panel_pwr_seq_pkg;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_BYTE = 2'd1,
        K_WORD = 2'd2,
        K_WAIT = 2'd3
    } step_kind_t;

    typedef struct packed {
        step_kind_t  kind;
        logic [7:0]  op;
        logic [15:0] val;
    } step_t;

    localparam int WARM_STEPS = 6;
    localparam int ON_STEPS   = 47;
    localparam int OFF_STEPS  = 4;
    localparam int TABLE_LEN  = ON_STEPS + OFF_STEPS;

    function automatic step_t s_cmd(input logic [7:0] o);
        return '{K_CMD, o, 16'h0000};
    endfunction

    function automatic step_t s_byte(input logic [7:0] o, input logic [7:0] v);
        return '{K_BYTE, o, {8'h00, v}};
    endfunction

    function automatic step_t s_word(input logic [7:0] o, input logic [15:0] v);
        return '{K_WORD, o, v};
    endfunction

    function automatic step_t s_wait();
        return '{K_WAIT, 8'h00, 16'h0000};
    endfunction

    // Step lookup: warm-up, configuration, display-on, then shutdown.
    function automatic step_t step_at(input int unsigned i);
        step_t s;
        case (i)
            0, 2, 4:  s = s_cmd(8'h00);
            1, 3, 5:  s = s_wait();
            6:  s = s_byte(8'hB0, 8'h17);
            7:  s = s_byte(8'hBC, 8'h80);
            8:  s = s_byte(8'h3B, 8'h00);
            9:  s = s_byte(8'hB0, 8'h16);
            10: s = s_word(8'hB8, 16'hFFF9);
            11: s = s_cmd(8'h11);
            12: s = s_byte(8'hBA, 8'h01);
            13: s = s_byte(8'hBB, 8'h00);
            14: s = s_byte(8'h3A, 8'h60);
            15: s = s_byte(8'hBF, 8'h10);
            16: s = s_byte(8'hB1, 8'h56);
            17: s = s_byte(8'hB2, 8'h33);
            18, 19: s = s_byte(8'hB3, 8'h11);
            20: s = s_byte(8'hB4, 8'h02);
            21: s = s_byte(8'hB5, 8'h2B);
            22: s = s_byte(8'hB6, 8'h40);
            23: s = s_byte(8'hB7, 8'h03);
            24: s = s_byte(8'hB9, 8'h04);
            25: s = s_byte(8'hBD, 8'h04);
            26: s = s_byte(8'hBE, 8'h00);
            27: s = s_byte(8'hC0, 8'h11);
            28: s = s_byte(8'hC1, 8'h11);
            29: s = s_byte(8'hC2, 8'h11);
            30: s = s_word(8'hC3, 16'h2040);
            31: s = s_word(8'hC4, 16'h60C0);
            32: s = s_word(8'hC5, 16'h1020);
            33: s = s_word(8'hC6, 16'h60C0);
            34: s = s_word(8'hC7, 16'h5533);
            35: s = s_byte(8'hC8, 8'h00);
            36: s = s_byte(8'hC9, 8'h00);
            37: s = s_byte(8'hCA, 8'h00);
            38: s = s_word(8'hEC, 16'h01F0);
            39: s = s_byte(8'hCF, 8'h02);
            40: s = s_word(8'hD0, 16'h0804);
            41: s = s_byte(8'hD1, 8'h01);
            42: s = s_word(8'hD2, 16'h0000);
            43: s = s_word(8'hD3, 16'h0D0E);
            44: s = s_word(8'hD4, 16'h11A4);
            45: s = s_byte(8'hD5, 8'h0E);
            46: s = s_cmd(8'h29);
            47: s = s_cmd(8'h28);
            48: s = s_word(8'hB8, 16'h8002);
            49: s = s_cmd(8'h10);
            50: s = s_byte(8'hB0, 8'h00);
            default: s = s_cmd(8'h00);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/panel_pwr_seq_rom.sv
// Step table read port: maps a step index to its decoded step.
// Assumes: idx stays below TABLE_LEN; larger values read a harmless command.
module panel_pwr_seq_rom
    import panel_pwr_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);

    // Combinational lookup of the current step.
    always_comb step = step_at(32'(idx));

endmodule

// File: rtl/panel_pwr_seq_delay.sv
// Wait timer: after a start pulse, raises expired on the WAIT_CYC-th cycle.
// Assumes: start is not pulsed again while a wait is running.
module panel_pwr_seq_delay #(
    parameter int WAIT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);

    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt;
    logic          run;

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= LOAD;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

endmodule

// File: rtl/panel_pwr_seq_ctrl.sv
// Sequencer control: walks the step table, runs the writer handshake,
// handles wait steps, aborts on warm-up failure, accumulates later errors
// and tracks the panel state.
// Assumes: the writer asserts done for one cycle per transaction, and err
// is only meaningful together with done.
module panel_pwr_seq_ctrl
    import panel_pwr_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on_req,
    input  logic             off_req,
    input  step_kind_t       kind,
    input  logic             wr_done,
    input  logic             wr_err,
    input  logic             tmr_exp,
    output logic [IDX_W-1:0] idx,
    output logic             tmr_start,
    output logic             wr_valid,
    output logic             busy,
    output logic             panel_on,
    output logic             seq_done,
    output logic             seq_err
);

    localparam logic [IDX_W-1:0] OFF_BASE = IDX_W'(ON_STEPS);
    localparam logic [IDX_W-1:0] ON_LAST  = IDX_W'(ON_STEPS - 1);
    localparam logic [IDX_W-1:0] OFF_LAST = IDX_W'(TABLE_LEN - 1);
    localparam logic [IDX_W-1:0] WARM_END = IDX_W'(WARM_STEPS);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} st_t;

    st_t  st;
    logic up;
    logic acc;
    logic last_step;
    logic in_warm;

    // Decode of where the current index sits in its list.
    always_comb begin
        last_step = up ? (idx == ON_LAST) : (idx == OFF_LAST);
        in_warm   = up && (idx < WARM_END);
    end

    assign wr_valid  = (st == ST_RUN) && (kind != K_WAIT);
    assign tmr_start = (st == ST_RUN) && (kind == K_WAIT);
    assign busy      = (st != ST_IDLE);

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            idx      <= '0;
            up       <= 1'b0;
            acc      <= 1'b0;
            panel_on <= 1'b0;
            seq_done <= 1'b0;
            seq_err  <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (on_req) begin
                        if (panel_on) begin
                            seq_done <= 1'b1;
                            seq_err  <= 1'b0;
                        end else begin
                            st  <= ST_RUN;
                            idx <= '0;
                            up  <= 1'b1;
                            acc <= 1'b0;
                        end
                    end else if (off_req && panel_on) begin
                        st  <= ST_RUN;
                        idx <= OFF_BASE;
                        up  <= 1'b0;
                        acc <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (kind == K_WAIT) begin
                        st <= ST_WAIT;
                    end else if (wr_done) begin
                        if (wr_err && in_warm) begin
                            st       <= ST_IDLE;
                            seq_done <= 1'b1;
                            seq_err  <= 1'b1;
                        end else if (last_step) begin
                            st       <= ST_IDLE;
                            seq_done <= 1'b1;
                            seq_err  <= acc | wr_err;
                            panel_on <= up;
                        end else begin
                            acc <= acc | wr_err;
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tmr_exp) begin
                        idx <= idx + 1'b1;
                        st  <= ST_RUN;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/panel_pwr_seq.sv
// Top of the panel power sequencer: ties the step table, wait timer and
// control together and exposes the command-writer handshake.
// Assumes: CLK_HZ is the clock frequency; one wait step lasts at least
// CLK_HZ/1000 cycles.
module panel_pwr_seq
    import panel_pwr_seq_pkg::*;
#(
    parameter int CLK_HZ = 250_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        on_req,
    input  logic        off_req,
    input  logic        wr_done,
    input  logic        wr_err,
    output logic        wr_valid,
    output logic [1:0]  wr_kind,
    output logic [7:0]  wr_op,
    output logic [15:0] wr_data,
    output logic        busy,
    output logic        panel_on,
    output logic        seq_done,
    output logic        seq_err
);

    localparam int WAIT_CYC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
    localparam int IDX_W    = $clog2(TABLE_LEN);

    logic [IDX_W-1:0] idx;
    step_t            step;
    logic             tmr_start;
    logic             tmr_exp;

    panel_pwr_seq_rom #(.IDX_W(IDX_W)) u_rom (
        .idx  (idx),
        .step (step)
    );

    panel_pwr_seq_delay #(.WAIT_CYC(WAIT_CYC)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_exp)
    );

    panel_pwr_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .on_req    (on_req),
        .off_req   (off_req),
        .kind      (step.kind),
        .wr_done   (wr_done),
        .wr_err    (wr_err),
        .tmr_exp   (tmr_exp),
        .idx       (idx),
        .tmr_start (tmr_start),
        .wr_valid  (wr_valid),
        .busy      (busy),
        .panel_on  (panel_on),
        .seq_done  (seq_done),
        .seq_err   (seq_err)
    );

    assign wr_kind = step.kind;
    assign wr_op   = step.op;
    assign wr_data = step.val;

endmodule

// File: rtl/panel_pwr_seq_chk.sv
// Checker for the panel power sequencer, bound to every instance of the top.
// Assumes: synchronous active-low reset on rst_n.
module panel_pwr_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic        wr_done,
    input logic [1:0]  wr_kind,
    input logic [7:0]  wr_op,
    input logic [15:0] wr_data,
    input logic        busy,
    input logic        panel_on,
    input logic        seq_done
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !panel_on && !seq_done && !wr_valid));

    assert_byte_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_kind == 2'd1) |-> (wr_data[15:8] == 8'h00));

    assert_no_wait_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_kind != 2'd3));

    assert_on_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_on) |-> seq_done);

    assert_off_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_on) |-> seq_done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !busy);

    assert_valid_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy);

    assert_hold_fields_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_done) |=>
            (wr_valid && $stable(wr_kind) && $stable(wr_op) && $stable(wr_data)));

endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_done  (wr_done),
    .wr_kind  (wr_kind),
    .wr_op    (wr_op),
    .wr_data  (wr_data),
    .busy     (busy),
    .panel_on (panel_on),
    .seq_done (seq_done)
);

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb;

    localparam int CLK_HZ = 20_000;
    localparam int DLY    = CLK_HZ / 1000;
    localparam int LAT    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        on_req = 1'b0;
    logic        off_req = 1'b0;
    logic        wr_done = 1'b0;
    logic        wr_err = 1'b0;
    logic        wr_valid;
    logic [1:0]  wr_kind;
    logic [7:0]  wr_op;
    logic [15:0] wr_data;
    logic        busy;
    logic        panel_on;
    logic        seq_done;
    logic        seq_err;

    panel_pwr_seq #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
        .wr_done(wr_done), .wr_err(wr_err), .wr_valid(wr_valid),
        .wr_kind(wr_kind), .wr_op(wr_op), .wr_data(wr_data),
        .busy(busy), .panel_on(panel_on), .seq_done(seq_done), .seq_err(seq_err)
    );

    always #2 clk = ~clk;

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected transaction list: {kind, op, value}.
    function automatic logic [25:0] c0(input logic [7:0] o);
        return {2'd0, o, 16'h0000};
    endfunction
    function automatic logic [25:0] b1(input logic [7:0] o, input logic [7:0] v);
        return {2'd1, o, 8'h00, v};
    endfunction
    function automatic logic [25:0] w2(input logic [7:0] o, input logic [15:0] v);
        return {2'd2, o, v};
    endfunction

    function automatic logic [25:0] exp_tx(input int i);
        case (i)
            0, 1, 2: return c0(8'h00);
            3:  return b1(8'hB0, 8'h17);
            4:  return b1(8'hBC, 8'h80);
            5:  return b1(8'h3B, 8'h00);
            6:  return b1(8'hB0, 8'h16);
            7:  return w2(8'hB8, 16'hFFF9);
            8:  return c0(8'h11);
            9:  return b1(8'hBA, 8'h01);
            10: return b1(8'hBB, 8'h00);
            11: return b1(8'h3A, 8'h60);
            12: return b1(8'hBF, 8'h10);
            13: return b1(8'hB1, 8'h56);
            14: return b1(8'hB2, 8'h33);
            15, 16: return b1(8'hB3, 8'h11);
            17: return b1(8'hB4, 8'h02);
            18: return b1(8'hB5, 8'h2B);
            19: return b1(8'hB6, 8'h40);
            20: return b1(8'hB7, 8'h03);
            21: return b1(8'hB9, 8'h04);
            22: return b1(8'hBD, 8'h04);
            23: return b1(8'hBE, 8'h00);
            24: return b1(8'hC0, 8'h11);
            25: return b1(8'hC1, 8'h11);
            26: return b1(8'hC2, 8'h11);
            27: return w2(8'hC3, 16'h2040);
            28: return w2(8'hC4, 16'h60C0);
            29: return w2(8'hC5, 16'h1020);
            30: return w2(8'hC6, 16'h60C0);
            31: return w2(8'hC7, 16'h5533);
            32: return b1(8'hC8, 8'h00);
            33: return b1(8'hC9, 8'h00);
            34: return b1(8'hCA, 8'h00);
            35: return w2(8'hEC, 16'h01F0);
            36: return b1(8'hCF, 8'h02);
            37: return w2(8'hD0, 16'h0804);
            38: return b1(8'hD1, 8'h01);
            39: return w2(8'hD2, 16'h0000);
            40: return w2(8'hD3, 16'h0D0E);
            41: return w2(8'hD4, 16'h11A4);
            42: return b1(8'hD5, 8'h0E);
            43: return c0(8'h29);
            44: return c0(8'h28);
            45: return w2(8'hB8, 16'h8002);
            46: return c0(8'h10);
            47: return b1(8'hB0, 8'h00);
            default: return 26'h0;
        endcase
    endfunction

    // Reference state kept by the bench.
    logic [25:0] expq[$];
    int  tx_seq = 0;
    int  tx_total = 0;
    int  fail_a = -1;
    int  fail_b = -1;
    int  res_cnt = 0;
    bit  last_err = 1'b0;
    bit  seq_up = 1'b0;
    bit  seq_abort = 1'b0;
    bit  model_on = 1'b0;
    int  wl = 0;
    int  gap = 0;
    bit  warm_prev = 1'b0;
    int  b3_seen = 0;
    logic [25:0] held;

    task automatic start_seq(input bit up, input int fa, input int fb);
        expq.delete();
        if (up) for (int i = 0; i < 44; i++) expq.push_back(exp_tx(i));
        else    for (int i = 44; i < 48; i++) expq.push_back(exp_tx(i));
        tx_seq = 0; fail_a = fa; fail_b = fb; seq_up = up; warm_prev = 1'b0;
        seq_abort = up && ((fa >= 0 && fa < 3) || (fb >= 0 && fb < 3));
    endtask

    // Writer model and per-clock comparison with the reference.
    always @(negedge clk) begin
        if (rst_n) begin
            if (seq_done) begin
                res_cnt++;
                last_err = seq_err;
                model_on = seq_up && !seq_abort;
            end
            chk(panel_on == model_on, "R3/R7/R8", "panel state per clock", panel_on, model_on);
            if (wr_valid && expq.size() == 0)
                chk(1'b0, "R10/R11", "unexpected transaction", wr_op, 0);
            if (wr_done) begin
                wr_done = 1'b0;
                wr_err  = 1'b0;
                gap = wr_valid ? 0 : 1;
                wl = 0;
            end else if (wr_valid) begin
                if (wl == 0) begin
                    held = {wr_kind, wr_op, wr_data};
                    if (warm_prev)
                        chk(gap >= DLY, "R2", "idle cycles after warm-up command", gap, DLY);
                end
                if (wl == LAT) begin
                    chk({wr_kind, wr_op, wr_data} == held, "R12", "fields held",
                        int'({wr_kind, wr_op, wr_data}), int'(held));
                    if (expq.size() != 0) begin
                        logic [25:0] e;
                        e = expq.pop_front();
                        chk({wr_kind, wr_op, wr_data} == e, "R4/R5", "transaction",
                            int'({wr_kind, wr_op, wr_data}), int'(e));
                    end
                    if (wr_op == 8'hB3) b3_seen++;
                    warm_prev = seq_up && tx_seq < 3;
                    wr_err  = (tx_seq == fail_a) || (tx_seq == fail_b);
                    wr_done = 1'b1;
                    tx_seq++;
                    tx_total++;
                    wl = 0;
                end else begin
                    wl++;
                end
            end else begin
                gap++;
            end
        end
    end

    task automatic pulse(input bit on, input bit off);
        @(negedge clk);
        on_req = on; off_req = off;
        @(negedge clk);
        on_req = 1'b0; off_req = 1'b0;
    endtask

    task automatic wait_result(input int r0);
        for (int i = 0; i < 5000 && res_cnt == r0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "R11", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        int r0;
        int t0;
        int bz;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !panel_on && !seq_done && !wr_valid, "R1", "reset outputs",
            {busy, panel_on, seq_done, wr_valid}, 0);

        // R10: power-off while the panel is off does nothing.
        r0 = res_cnt; t0 = tx_total; bz = 0;
        pulse(1'b0, 1'b1);
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (busy) bz++; end
        chk(bz == 0, "R10", "busy cycles", bz, 0);
        chk(res_cnt == r0, "R10", "results", res_cnt, r0);
        chk(tx_total == t0, "R10", "transactions", tx_total, t0);

        // R3: second warm-up command fails.
        start_seq(1'b1, 1, -1);
        r0 = res_cnt;
        pulse(1'b1, 1'b0);
        wait_result(r0);
        chk(last_err == 1'b1, "R3", "abort error flag", last_err, 1);
        chk(tx_seq == 2, "R3", "transactions before abort", tx_seq, 2);
        repeat (60) @(negedge clk);
        chk(tx_seq == 2 && !busy, "R3", "nothing after abort", tx_seq, 2);
        chk(panel_on == 1'b0, "R3", "panel stays off", panel_on, 0);

        // R14: both requests in the same idle cycle; power-on wins.
        // R2 R4 R7 R11: clean power-on, with requests injected while busy.
        start_seq(1'b1, -1, -1);
        b3_seen = 0;
        r0 = res_cnt;
        pulse(1'b1, 1'b1);
        chk(busy == 1'b1, "R14", "busy after simultaneous requests", busy, 1);
        while (tx_seq < 10) @(negedge clk);
        chk(busy == 1'b1, "R11", "busy mid-sequence", busy, 1);
        pulse(1'b1, 1'b1);
        wait_result(r0);
        chk(last_err == 1'b0, "R7", "power-on error flag", last_err, 0);
        chk(tx_seq == 44, "R4", "power-on transaction count", tx_seq, 44);
        chk(expq.size() == 0, "R7", "list finished with display-on", expq.size(), 0);
        chk(b3_seen == 2, "R5", "repeated 0xB3 writes", b3_seen, 2);
        repeat (20) @(negedge clk);
        chk(res_cnt == r0 + 1, "R11", "single completion", res_cnt, r0 + 1);
        chk(panel_on == 1'b1, "R7", "panel on", panel_on, 1);

        // R9: power-on while already on.
        t0 = tx_total;
        @(negedge clk); on_req = 1'b1;
        @(negedge clk); on_req = 1'b0;
        chk(seq_done && !seq_err && !busy, "R9", "immediate success",
            {seq_done, seq_err, busy}, 3'b100);
        repeat (10) @(negedge clk);
        chk(tx_total == t0, "R9", "no transactions", tx_total, t0);

        // R8: clean power-off.
        start_seq(1'b0, -1, -1);
        r0 = res_cnt;
        pulse(1'b0, 1'b1);
        wait_result(r0);
        chk(last_err == 1'b0, "R8", "power-off error flag", last_err, 0);
        chk(tx_seq == 4 && expq.size() == 0, "R8", "power-off transactions", tx_seq, 4);
        chk(panel_on == 1'b0, "R8", "panel off", panel_on, 0);

        // R6: configuration errors accumulate.
        start_seq(1'b1, 10, 30);
        r0 = res_cnt;
        pulse(1'b1, 1'b0);
        wait_result(r0);
        chk(last_err == 1'b1, "R6", "accumulated error", last_err, 1);
        chk(tx_seq == 44, "R6", "full list issued", tx_seq, 44);
        chk(panel_on == 1'b1, "R6", "panel on despite error", panel_on, 1);

        // R13: power-off error accumulated.
        start_seq(1'b0, 2, -1);
        r0 = res_cnt;
        pulse(1'b0, 1'b1);
        wait_result(r0);
        chk(last_err == 1'b1, "R13", "power-off error", last_err, 1);
        chk(tx_seq == 4, "R13", "full power-off list", tx_seq, 4);
        chk(panel_on == 1'b0, "R13", "panel off", panel_on, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule